// File: doc/BRIEF.md
# Eight-Bit Stack Processor Core

A small multi-cycle processor with eight 8-bit general registers and a single 256-byte memory that holds both program and data. Register 7 serves as the stack pointer, so the stack sits in the same memory as the program. Every instruction takes two clock cycles. In the first cycle the core reads the opcode and the two bytes after it. In the second cycle it carries out the instruction and updates the program counter.

The opcode encodes its own length and tells the core whether it loads the program counter. Bits 7:6 plus one give the length in bytes. When bit 4 is clear the program counter advances by that length. When bit 4 is set the instruction loads the program counter itself.

The memory is filled through a preload port while reset is held. The core then runs after reset is released. Results leave the core through a print port that carries one byte and a one-cycle valid strobe. A sticky halted flag reports the end of a program. A sticky illegal flag reports an unknown opcode.

Top module: `byte_cpu`

## Requirements
- R1: While `rst` is high, a byte on `ld_data` with `ld_en` high is written to memory at `ld_addr` on the clock edge. In reset, `halted`, `illegal` and `out_valid` are low, and R7 holds 0xF4.
- R2: Each instruction takes exactly two clock cycles. Its length is opcode bits [7:6] plus one. Operand A is the byte at PC+1 and operand B is the byte at PC+2. When opcode bit 4 is clear, PC advances by the length. A register operand names register (operand & 7).
- R3: LDI (0x82) writes operand B into the register named by operand A.
- R4: ADD (0xA0) and MUL (0xA2) write regA+regB and regA*regB, each taken modulo 256, into regA.
- R5: PRN (0x47) drives the named register's value on `out_data` with `out_valid` high for exactly one cycle.
- R6: PUSH (0x45) first decrements SP modulo 256, then stores the named register at memory[SP].
- R7: POP (0x46) loads memory[SP] into the named register, then increments SP modulo 256.
- R8: CALL (0x50) decrements SP, stores PC+2 at memory[SP] and loads PC from the register named by operand A. RET (0x11) loads PC from memory[SP], then increments SP.
- R9: HLT (0x01) sets `halted`, which stays high until reset. No instruction after it executes, so no print follows.
- R10: Any other opcode sets both `halted` and `illegal`, and no further print occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Preload write enable |
| ld_addr | input | 8 | Preload address |
| ld_data | input | 8 | Preload byte |
| out_valid | output | 1 | Print strobe |
| out_data | output | 8 | Printed byte |
| halted | output | 1 | Core stopped |
| illegal | output | 1 | Stopped on an unknown opcode |

## Verification
The bench sweeps a grid of operand pairs through ADD and MUL, including pairs whose results overflow 8 bits. A core that failed to truncate a result, or that took its operands from the wrong bytes, would print the wrong sums and products.

Stack programs cover several failure modes:
- Dropping the SP decrement before a store would show up as a wrong pushed SP value.
- Post-incrementing in the wrong order would show up as a wrong popped value.
- Storing the wrong return address would make the final print disagree.
- Failing to wrap SP between 0x00 and 0xFF would leave the wrong SP value after the wrap.

Halt and unknown-opcode programs place a print after the stopping instruction. A core that kept fetching would emit it. The cycle count to `halted` exposes any instruction that does not take exactly two cycles.

// File: rtl/byte_cpu_pkg.sv
package byte_cpu_pkg;
    localparam int DW      = 8;
    localparam int AW      = 8;
    localparam int NREG    = 8;
    localparam int RIW     = $clog2(NREG);
    localparam int SP_IDX  = NREG - 1;
    localparam logic [DW-1:0] SP_INIT = 8'hF4;

    typedef enum logic [DW-1:0] {
        OP_HLT  = 8'h01,
        OP_LDI  = 8'h82,
        OP_PRN  = 8'h47,
        OP_MUL  = 8'hA2,
        OP_ADD  = 8'hA0,
        OP_PUSH = 8'h45,
        OP_POP  = 8'h46,
        OP_CALL = 8'h50,
        OP_RET  = 8'h11
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_EXEC,
        ST_STOP
    } phase_e;

    typedef struct packed {
        logic [DW-1:0] op;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
    } instr_t;

    function automatic logic [AW-1:0] instr_len(input logic [DW-1:0] op);
        return AW'(op[7:6]) + AW'(1);
    endfunction

    function automatic logic loads_pc(input logic [DW-1:0] op);
        return op[4];
    endfunction

    function automatic logic [DW-1:0] arith(input logic [DW-1:0] op,
                                            input logic [DW-1:0] x,
                                            input logic [DW-1:0] y);
        logic [2*DW-1:0] prod;
        prod = x * y;
        if (op == OP_MUL) return prod[DW-1:0];
        return DW'(x + y);
    endfunction
endpackage

// File: rtl/byte_cpu_mem.sv
module byte_cpu_mem
    import byte_cpu_pkg::*;
#(
    parameter int NRD = 3
) (
    input  logic                  clk,
    input  logic                  ld_en,
    input  logic [AW-1:0]         ld_addr,
    input  logic [DW-1:0]         ld_data,
    input  logic                  we,
    input  logic [AW-1:0]         waddr,
    input  logic [DW-1:0]         wdata,
    input  logic [NRD-1:0][AW-1:0] raddr,
    output logic [NRD-1:0][DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_en)
            cells[ld_addr] <= ld_data;
        else if (we)
            cells[waddr] <= wdata;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = cells[raddr[g]];
    end
endmodule

// File: rtl/byte_cpu_regs.sv
module byte_cpu_regs
    import byte_cpu_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [RIW-1:0] ra_idx,
    input  logic [RIW-1:0] rb_idx,
    output logic [DW-1:0]  ra_val,
    output logic [DW-1:0]  rb_val,
    output logic [DW-1:0]  sp,
    input  logic           we,
    input  logic [RIW-1:0] widx,
    input  logic [DW-1:0]  wdata,
    input  logic           sp_we,
    input  logic [DW-1:0]  sp_wdata
);
    logic [DW-1:0] rf [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DW-1:0] INIT = (g == SP_IDX) ? SP_INIT : '0;
        always_ff @(posedge clk) begin
            if (rst)
                rf[g] <= INIT;
            else if (we && widx == RIW'(g))
                rf[g] <= wdata;
            else if (sp_we && g == SP_IDX)
                rf[g] <= sp_wdata;
        end
    end

    assign ra_val = rf[ra_idx];
    assign rb_val = rf[rb_idx];
    assign sp     = rf[SP_IDX];
endmodule

// File: rtl/byte_cpu_ctrl.sv
module byte_cpu_ctrl
    import byte_cpu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    output logic [2:0][AW-1:0]    m_raddr,
    input  logic [2:0][DW-1:0]    m_rdata,
    output logic                  m_we,
    output logic [AW-1:0]         m_waddr,
    output logic [DW-1:0]         m_wdata,
    output logic [RIW-1:0]        ra_idx,
    output logic [RIW-1:0]        rb_idx,
    input  logic [DW-1:0]         ra_val,
    input  logic [DW-1:0]         rb_val,
    input  logic [DW-1:0]         sp,
    output logic                  rf_we,
    output logic [RIW-1:0]        rf_widx,
    output logic [DW-1:0]         rf_wdata,
    output logic                  sp_we,
    output logic [DW-1:0]         sp_wdata,
    output logic                  out_valid,
    output logic [DW-1:0]         out_data,
    output logic                  halted,
    output logic                  illegal
);
    phase_e        phase;
    logic [AW-1:0] pc;
    instr_t        ir;

    logic          do_print, do_stop, bad_op;
    logic [AW-1:0] pc_target;
    logic [DW-1:0] sp_dec, sp_inc;

    assign m_raddr[0] = (phase == ST_FETCH) ? pc : sp;
    assign m_raddr[1] = AW'(pc + AW'(1));
    assign m_raddr[2] = AW'(pc + AW'(2));

    assign ra_idx = ir.a[RIW-1:0];
    assign rb_idx = ir.b[RIW-1:0];
    assign sp_dec = DW'(sp - DW'(1));
    assign sp_inc = DW'(sp + DW'(1));

    always_comb begin
        m_we      = 1'b0;
        m_waddr   = sp_dec;
        m_wdata   = ra_val;
        rf_we     = 1'b0;
        rf_widx   = ir.a[RIW-1:0];
        rf_wdata  = ir.b;
        sp_we     = 1'b0;
        sp_wdata  = sp_dec;
        do_print  = 1'b0;
        do_stop   = 1'b0;
        bad_op    = 1'b0;
        pc_target = ra_val;
        if (phase == ST_EXEC) begin
            case (ir.op)
                OP_LDI: rf_we = 1'b1;
                OP_ADD, OP_MUL: begin
                    rf_we    = 1'b1;
                    rf_wdata = arith(ir.op, ra_val, rb_val);
                end
                OP_PRN: do_print = 1'b1;
                OP_PUSH: begin
                    m_we  = 1'b1;
                    sp_we = 1'b1;
                end
                OP_POP: begin
                    rf_we    = 1'b1;
                    rf_wdata = m_rdata[0];
                    sp_we    = 1'b1;
                    sp_wdata = sp_inc;
                end
                OP_CALL: begin
                    m_we    = 1'b1;
                    m_wdata = DW'(pc + instr_len(ir.op));
                    sp_we   = 1'b1;
                end
                OP_RET: begin
                    pc_target = m_rdata[0];
                    sp_we     = 1'b1;
                    sp_wdata  = sp_inc;
                end
                OP_HLT: do_stop = 1'b1;
                default: begin
                    do_stop = 1'b1;
                    bad_op  = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= ST_FETCH;
            pc        <= '0;
            ir        <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            halted    <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= do_print;
            if (do_print) out_data <= ra_val;
            case (phase)
                ST_FETCH: begin
                    ir    <= '{op: m_rdata[0], a: m_rdata[1], b: m_rdata[2]};
                    phase <= ST_EXEC;
                end
                ST_EXEC: begin
                    pc <= loads_pc(ir.op) ? pc_target : AW'(pc + instr_len(ir.op));
                    if (do_stop) begin
                        phase   <= ST_STOP;
                        halted  <= 1'b1;
                        illegal <= bad_op;
                    end else begin
                        phase <= ST_FETCH;
                    end
                end
                default: phase <= ST_STOP;
            endcase
        end
    end

    AST_PRINT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R5
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc) && !out_valid)); // R9
    AST_ILLEGAL_STOPS: assert property (@(posedge clk) disable iff (rst)
        illegal |-> halted); // R10
    AST_PUSH_PREDEC: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_EXEC && ir.op == OP_PUSH) |=> (sp == DW'($past(sp) - DW'(1)))); // R6
    AST_POP_POSTINC: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_EXEC && ir.op == OP_POP && ir.a[RIW-1:0] != RIW'(SP_IDX))
        |=> (sp == DW'($past(sp) + DW'(1)))); // R7
endmodule

// File: rtl/byte_cpu.sv
module byte_cpu
    import byte_cpu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          halted,
    output logic          illegal
);
    logic [2:0][AW-1:0] m_raddr;
    logic [2:0][DW-1:0] m_rdata;
    logic               core_we;
    logic [AW-1:0]      m_waddr;
    logic [DW-1:0]      m_wdata;
    logic [RIW-1:0]     ra_idx, rb_idx, rf_widx;
    logic [DW-1:0]      ra_val, rb_val, sp, rf_wdata, sp_wdata;
    logic               rf_we, sp_we;

    byte_cpu_mem #(.NRD(3)) u_mem (
        .clk(clk), .ld_en(ld_en && rst), .ld_addr(ld_addr), .ld_data(ld_data),
        .we(core_we && !rst), .waddr(m_waddr), .wdata(m_wdata),
        .raddr(m_raddr), .rdata(m_rdata)
    );

    byte_cpu_regs u_regs (
        .clk(clk), .rst(rst), .ra_idx(ra_idx), .rb_idx(rb_idx),
        .ra_val(ra_val), .rb_val(rb_val), .sp(sp),
        .we(rf_we && !rst), .widx(rf_widx), .wdata(rf_wdata),
        .sp_we(sp_we && !rst), .sp_wdata(sp_wdata)
    );

    byte_cpu_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .m_raddr(m_raddr), .m_rdata(m_rdata), .m_we(core_we),
        .m_waddr(m_waddr), .m_wdata(m_wdata),
        .ra_idx(ra_idx), .rb_idx(rb_idx), .ra_val(ra_val), .rb_val(rb_val), .sp(sp),
        .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
        .sp_we(sp_we), .sp_wdata(sp_wdata),
        .out_valid(out_valid), .out_data(out_data),
        .halted(halted), .illegal(illegal)
    );
endmodule

// File: tb/byte_cpu_test.sv
module byte_cpu_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;
    localparam int RUN_LIMIT  = 400;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_en = 1'b0;
    logic [7:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic       out_valid, halted, illegal;
    logic [7:0] out_data;

    int checks = 0, failures = 0, cycles = 0;
    logic [7:0] prog [256];
    logic [7:0] pr [32];
    int pcnt = 0;
    int run_cycles = 0;

    byte_cpu uut (.clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr),
                  .ld_data(ld_data), .out_valid(out_valid), .out_data(out_data),
                  .halted(halted), .illegal(illegal));

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cycles++;
        if (!rst && out_valid && pcnt < 32) begin
            pr[pcnt] = out_data;
            pcnt++;
        end
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) prog[i] = 8'h00;
    endtask

    task automatic run();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 256; i++) begin
            ld_en = 1'b1; ld_addr = 8'(i); ld_data = prog[i];
            @(negedge clk);
        end
        ld_en = 1'b0;
        pcnt = 0;
        rst = 1'b0;
        run_cycles = 0;
        while (run_cycles < RUN_LIMIT) begin
            @(negedge clk);
            run_cycles++;
            if (halted) break;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 halted in reset", int'(halted), 0);
        check("R1 illegal in reset", int'(illegal), 0);
        check("R1 out_valid in reset", int'(out_valid), 0);

        // R1, R2, R5: SP reset value, timing of LDI/PRN/HLT
        clear_prog();
        prog[0] = 8'h47; prog[1] = 8'h07;               // PRN R7
        prog[2] = 8'h82; prog[3] = 8'h0A; prog[4] = 8'h3C; // LDI R2,0x3C (index 10 & 7)
        prog[5] = 8'h47; prog[6] = 8'h02;               // PRN R2
        prog[7] = 8'h01;                                 // HLT
        prog[8] = 8'h47; prog[9] = 8'h02;               // PRN after halt
        run();
        check("R1 sp reset value", int'(pr[0]), 8'hF4);
        check("R3 LDI with masked index", int'(pr[1]), 8'h3C);
        check("R9 print count after HLT", pcnt, 2);
        check("R9 halted", int'(halted), 1);
        check("R9 not illegal", int'(illegal), 0);
        check("R2 two cycles per instruction", run_cycles, 8);
        @(negedge clk);
        check("R9 halted stays", int'(halted), 1);

        // R4: ADD and MUL sweep
        for (int i = 0; i < 12; i++) begin
            for (int j = 0; j < 12; j++) begin
                int a, b;
                a = (i * 23 + 1) % 256;
                b = (j * 29 + 7) % 256;
                clear_prog();
                prog[0]  = 8'h82; prog[1]  = 8'h00; prog[2]  = 8'(a);
                prog[3]  = 8'h82; prog[4]  = 8'h01; prog[5]  = 8'(b);
                prog[6]  = 8'hA0; prog[7]  = 8'h00; prog[8]  = 8'h01;
                prog[9]  = 8'h47; prog[10] = 8'h00;
                prog[11] = 8'h82; prog[12] = 8'h00; prog[13] = 8'(a);
                prog[14] = 8'hA2; prog[15] = 8'h00; prog[16] = 8'h01;
                prog[17] = 8'h47; prog[18] = 8'h00;
                prog[19] = 8'h01;
                run();
                check("R4 ADD result", int'(pr[0]), (a + b) % 256);
                check("R4 MUL result", int'(pr[1]), (a * b) % 256);
                check("R2 sweep print count", pcnt, 2);
            end
        end

        // R6, R7: push/pop order
        clear_prog();
        prog[0]  = 8'h82; prog[1]  = 8'h02; prog[2]  = 8'h5A; // LDI R2,0x5A
        prog[3]  = 8'h82; prog[4]  = 8'h04; prog[5]  = 8'hC3; // LDI R4,0xC3
        prog[6]  = 8'h45; prog[7]  = 8'h02;                   // PUSH R2
        prog[8]  = 8'h47; prog[9]  = 8'h07;                   // PRN R7
        prog[10] = 8'h45; prog[11] = 8'h04;                   // PUSH R4
        prog[12] = 8'h46; prog[13] = 8'h03;                   // POP R3
        prog[14] = 8'h46; prog[15] = 8'h05;                   // POP R5
        prog[16] = 8'h47; prog[17] = 8'h03;
        prog[18] = 8'h47; prog[19] = 8'h05;
        prog[20] = 8'h47; prog[21] = 8'h07;
        prog[22] = 8'h01;
        run();
        check("R6 SP after push", int'(pr[0]), 8'hF3);
        check("R7 last pushed popped first", int'(pr[1]), 8'hC3);
        check("R7 second pop", int'(pr[2]), 8'h5A);
        check("R7 SP restored", int'(pr[3]), 8'hF4);

        // R6, R7: SP wrap
        clear_prog();
        prog[0] = 8'h82; prog[1] = 8'h07; prog[2] = 8'h00; // LDI R7,0
        prog[3] = 8'h82; prog[4] = 8'h01; prog[5] = 8'h99; // LDI R1,0x99
        prog[6] = 8'h45; prog[7] = 8'h01;                  // PUSH R1 -> SP 0xFF
        prog[8] = 8'h47; prog[9] = 8'h07;
        prog[10] = 8'h46; prog[11] = 8'h06;                // POP R6 -> SP 0x00
        prog[12] = 8'h47; prog[13] = 8'h06;
        prog[14] = 8'h47; prog[15] = 8'h07;
        prog[16] = 8'h01;
        run();
        check("R6 SP wraps down", int'(pr[0]), 8'hFF);
        check("R7 pop at 0xFF", int'(pr[1]), 8'h99);
        check("R7 SP wraps up", int'(pr[2]), 8'h00);

        // R8: call / return
        clear_prog();
        prog[0]  = 8'h82; prog[1] = 8'h01; prog[2] = 8'h40; // LDI R1,0x40
        prog[3]  = 8'h50; prog[4] = 8'h01;                  // CALL R1
        prog[5]  = 8'h47; prog[6] = 8'h00;                  // PRN R0
        prog[7]  = 8'h01;
        prog[8'h40] = 8'h82; prog[8'h41] = 8'h00; prog[8'h42] = 8'h77; // LDI R0,0x77
        prog[8'h43] = 8'h47; prog[8'h44] = 8'h07;            // PRN R7
        prog[8'h45] = 8'h46; prog[8'h46] = 8'h02;            // POP R2 (return addr)
        prog[8'h47] = 8'h47; prog[8'h48] = 8'h02;            // PRN R2
        prog[8'h49] = 8'h45; prog[8'h4A] = 8'h02;            // PUSH R2
        prog[8'h4B] = 8'h11;                                 // RET
        run();
        check("R8 SP in subroutine", int'(pr[0]), 8'hF3);
        check("R8 stored return address", int'(pr[1]), 5);
        check("R8 RET resumes after CALL", int'(pr[2]), 8'h77);
        check("R8 print count", pcnt, 3);

        // R10: unknown opcode
        clear_prog();
        prog[0] = 8'h47; prog[1] = 8'h07;
        prog[2] = 8'hFF;
        prog[3] = 8'h47; prog[4] = 8'h07;
        run();
        check("R10 halted", int'(halted), 1);
        check("R10 illegal", int'(illegal), 1);
        check("R10 no print after", pcnt, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule